// File: doc/BRIEF.md
# Programmable Reed-Solomon Byte Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). It is meant to sit in a burst transmit path. The host takes a burst enable high and streams message bytes in through a valid/ready handshake. Each message byte leaves the block unchanged one cycle after it is accepted. When the K-th byte of a codeword has been taken, the block stops accepting input and emits 2t check bytes. These are the remainder of the message polynomial, shifted up by 2t, after division by the generator polynomial. The codeword is therefore K + 2t bytes long.

The message length K (16 to 255 in normal use, never zero) and the correction capability t (0 to 10) are runtime inputs. They are sampled only when a codeword begins. Setting t to zero turns the block into a plain byte pass-through with codeword markers. The generator coefficients for every legal t are computed at elaboration into a constant table, and t selects the row. The source must leave a gap of 2t byte slots after each message. Bytes offered during that gap are dropped.

Top module: `rs_byte_encoder`

## Requirements
- R1: Each accepted message byte appears on `out_data` with `out_valid` high on the clock edge after the edge that accepted it. Bytes keep their arrival order.
- R2: Right after the K-th message byte, exactly 2t check bytes follow, one per cycle with no gap. `out_last` is high only with the final byte of the codeword, so each codeword produces exactly K + 2t output bytes.
- R3: The check bytes make the whole codeword a multiple of the generator polynomial. The generator is the product of (x + a^i) for i = 0 to 2t−1, where a = 0x02 and the field reduction polynomial is x^8+x^4+x^3+x^2+1. The first output byte of the codeword is the highest-degree coefficient, so the check byte of highest degree comes out first. The codeword evaluates to zero at every root a^0 .. a^(2t−1).
- R4: `in_ready` is low during the 2t check-byte slots. Bytes offered there reach neither the output nor the next codeword's check bytes, and `in_ready` rises again in the slot after the last check byte.
- R5: With t = 0, the K message bytes pass through with no check bytes, and `out_last` is set on the K-th byte.
- R6: `cfg_k` and `cfg_t` are sampled together with the first byte of a codeword. A change made partway through a codeword takes effect only with the next codeword.
- R7: While `en` is low, `in_ready` is low and `out_valid` is low from the next edge on. Any partial codeword and its remainder are discarded, so the next codeword after `en` rises is encoded from a clean state.
- R8: During and after reset, `out_valid` and `out_last` are low. After reset is released, `in_ready` follows `en`.
- R9: Cycles inside the message interval in which `in_valid` is low produce no output and do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Burst enable; low clears the codeword state |
| cfg_k | input | KW (8) | Message length K in bytes, sampled at codeword start |
| cfg_t | input | TW (4) | Correctable byte count t, 0..T_MAX, sampled at codeword start |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input message byte |
| in_ready | output | 1 | Block can take a message byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Message or check byte |
| out_last | output | 1 | Final byte of the codeword |

## Verification
Two functions can meet in a single cycle. Configuration sampling at the codeword boundary can coincide with acceptance of the first byte. The remainder clear forced by `en` can also coincide with check-byte emission. The bench changes `cfg_k` and `cfg_t` in the middle of a message and expects the current codeword to keep the old length and roots. It also expects the following codeword to use the new values. A second test drops `en` one slot into the check-byte interval. A full codeword sent next must still evaluate to zero at every generator root, which it can only do if the half-shifted remainder was cleared.

// File: rtl/rs_gf_pkg.sv
package rs_gf_pkg;

   localparam int unsigned GF_W = 8;
   // low byte of x^8 + x^4 + x^3 + x^2 + 1
   localparam logic [GF_W-1:0] GF_RED = 8'h1D;

   typedef enum logic {PH_MSG, PH_PAR} rs_phase_e;

   // carry-less multiply with modular reduction
   function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                              input logic [GF_W-1:0] b);
      logic [GF_W-1:0] acc;
      logic [GF_W-1:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < GF_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[GF_W-1] ? ((sh << 1) ^ GF_RED) : (sh << 1);
      end
      return acc;
   endfunction

endpackage

// File: rtl/rs_gen_rom.sv
module rs_gen_rom
   import rs_gf_pkg::*;
#(
   parameter int T_MAX = 10,
   parameter int TW    = 4
) (
   input  logic [TW-1:0]                   t_sel,
   output logic [2*T_MAX-1:0][GF_W-1:0]    coef
);

   localparam int NP = 2 * T_MAX;

   typedef logic [NP-1:0][GF_W-1:0] row_t;
   typedef row_t [T_MAX:0]          tab_t;

   // expand prod (x + a^i) for every t; keep the non-leading terms
   function automatic tab_t build_tab();
      tab_t                    tab;
      logic [NP:0][GF_W-1:0]   p;
      logic [NP:0][GF_W-1:0]   q;
      logic [GF_W-1:0]         root;
      tab = '0;
      for (int tt = 0; tt <= T_MAX; tt++) begin
         p    = '0;
         p[0] = 8'h01;
         root = 8'h01;
         for (int i = 0; i < 2 * tt; i++) begin
            q[0] = gf_mul(p[0], root);
            for (int j = 1; j <= NP; j++) begin
               q[j] = gf_mul(p[j], root) ^ p[j-1];
            end
            p    = q;
            root = gf_mul(root, 8'h02);
         end
         for (int j = 0; j < NP; j++) begin
            tab[tt][j] = (j < 2 * tt) ? p[j] : '0;
         end
      end
      return tab;
   endfunction

   localparam tab_t GEN_TAB = build_tab();

   always_comb begin
      coef = '0;
      for (int tt = 0; tt <= T_MAX; tt++) begin
         if (int'(t_sel) == tt) coef = GEN_TAB[tt];
      end
   end

endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
   import rs_gf_pkg::*;
#(
   parameter int T_MAX = 10,
   parameter int TW    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          load,
   input  logic                          shift,
   input  logic [TW-1:0]                 t_sel,
   input  logic [GF_W-1:0]               din,
   input  logic [2*T_MAX-1:0][GF_W-1:0]  coef,
   output logic [GF_W-1:0]               par_top
);

   localparam int NP = 2 * T_MAX;

   logic [NP-1:0][GF_W-1:0] rem_q;
   logic [GF_W-1:0]         fb;

   // highest active remainder stage, position 2t-1
   always_comb begin
      par_top = '0;
      for (int i = 0; i < NP; i++) begin
         if (i + 1 == 2 * int'(t_sel)) par_top = rem_q[i];
      end
   end

   assign fb = din ^ par_top;

   generate
      for (genvar i = 0; i < NP; i++) begin : g_stage
         localparam int STG = i;
         logic [GF_W-1:0] prev;
         if (i == 0) begin : g_first
            assign prev = '0;
         end else begin : g_chain
            assign prev = rem_q[i-1];
         end

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               rem_q[i] <= '0;
            end else if (load) begin
               if (STG < 2 * int'(t_sel)) rem_q[i] <= prev ^ gf_mul(fb, coef[i]);
               else                       rem_q[i] <= '0;
            end else if (shift) begin
               if (STG < 2 * int'(t_sel)) rem_q[i] <= prev;
               else                       rem_q[i] <= '0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
   import rs_gf_pkg::*;
#(
   parameter int T_MAX = 10,
   parameter int TW    = 4,
   parameter int KW    = 8,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [KW-1:0] cfg_k,
   input  logic [TW-1:0] cfg_t,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          accept,
   output logic          emit,
   output logic          cw_end,
   output logic [TW-1:0] t_cur
);

   rs_phase_e      phase_q;
   logic [KW-1:0]  cnt_q;
   logic [PW-1:0]  pcnt_q;
   logic [KW-1:0]  k_q;
   logic [TW-1:0]  t_q;
   logic           boundary;
   logic [KW-1:0]  k_eff;
   logic           last_msg;
   logic           last_par;

   assign boundary = (phase_q == PH_MSG) && (cnt_q == '0);
   assign k_eff    = boundary ? cfg_k : k_q;
   assign t_cur    = boundary ? cfg_t : t_q;

   assign in_ready = en && (phase_q == PH_MSG);
   assign accept   = in_ready && in_valid;
   assign emit     = en && (phase_q == PH_PAR);
   assign last_msg = accept && (cnt_q == k_eff - KW'(1));
   assign last_par = emit && (int'(pcnt_q) + 1 == 2 * int'(t_q));
   assign cw_end   = (last_msg && (t_cur == '0)) || last_par;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_MSG;
         cnt_q   <= '0;
         pcnt_q  <= '0;
         k_q     <= '0;
         t_q     <= '0;
      end else if (!en) begin
         phase_q <= PH_MSG;
         cnt_q   <= '0;
         pcnt_q  <= '0;
      end else begin
         if (accept) begin
            if (boundary) begin
               k_q <= cfg_k;
               t_q <= cfg_t;
            end
            if (last_msg) begin
               cnt_q  <= '0;
               pcnt_q <= '0;
               if (t_cur != '0) phase_q <= PH_PAR;
            end else begin
               cnt_q <= cnt_q + KW'(1);
            end
         end
         if (emit) begin
            if (last_par) begin
               phase_q <= PH_MSG;
               pcnt_q  <= '0;
            end else begin
               pcnt_q <= pcnt_q + PW'(1);
            end
         end
      end
   end

   // R5: a bypass codeword never enters the check-byte phase
   a_r5_bypass_stays_msg: assert property (@(posedge clk) disable iff (!rst_n)
      (last_msg && (t_cur == '0) && en) |=> (phase_q == PH_MSG));

   // R2: check-byte phase runs until its last slot unless en drops
   a_r2_parity_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && !last_par) |=> (!en || emit));

endmodule

// File: rtl/rs_byte_encoder.sv
module rs_byte_encoder
   import rs_gf_pkg::*;
#(
   parameter  int T_MAX = 10,
   parameter  int KW    = 8,
   localparam int TW    = $clog2(T_MAX + 1),
   localparam int PW    = $clog2(2 * T_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [KW-1:0]   cfg_k,
   input  logic [TW-1:0]   cfg_t,
   input  logic            in_valid,
   input  logic [GF_W-1:0] in_data,
   output logic            in_ready,
   output logic            out_valid,
   output logic [GF_W-1:0] out_data,
   output logic            out_last
);

   generate
      if (T_MAX < 1 || 2 * T_MAX > 254 || KW < 1) begin : g_bad_cfg
         $error("rs_byte_encoder: T_MAX or KW outside the supported range");
      end
   endgenerate

   logic                          accept;
   logic                          emit;
   logic                          cw_end;
   logic [TW-1:0]                 t_cur;
   logic [2*T_MAX-1:0][GF_W-1:0]  coef;
   logic [GF_W-1:0]               par_top;

   rs_seq_ctrl #(.T_MAX(T_MAX), .TW(TW), .KW(KW), .PW(PW)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .cfg_k    (cfg_k),
      .cfg_t    (cfg_t),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .accept   (accept),
      .emit     (emit),
      .cw_end   (cw_end),
      .t_cur    (t_cur)
   );

   rs_gen_rom #(.T_MAX(T_MAX), .TW(TW)) i_rom (
      .t_sel (t_cur),
      .coef  (coef)
   );

   rs_parity_lfsr #(.T_MAX(T_MAX), .TW(TW)) i_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!en),
      .load    (accept),
      .shift   (emit),
      .t_sel   (t_cur),
      .din     (in_data),
      .coef    (coef),
      .par_top (par_top)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= accept || emit;
         out_data  <= accept ? in_data : par_top;
         out_last  <= cw_end;
      end
   end

   // R1: accepted byte shows up unchanged one edge later
   a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (out_valid && (out_data == $past(in_data))));

   // R4: the input is closed while check bytes are produced
   a_r4_closed_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      emit |-> !in_ready);

   // R7: disabling silences the output on the next edge
   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out_valid);

   // R2: the codeword marker only rides on a valid byte
   a_r2_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

endmodule

// File: tb/test_rs_byte_encoder.sv
module test_rs_byte_encoder;

   localparam int CLK_P = 10;
   localparam int CAP   = 320;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] cfg_k = 8'd16;
   logic [3:0] cfg_t = 4'd0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_last;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] cap_d [CAP];
   bit         cap_l [CAP];
   int         cap_n = 0;

   always #(CLK_P/2) clk = ~clk;

   rs_byte_encoder i_rs_byte_encoder (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_k(cfg_k), .cfg_t(cfg_t),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   always @(negedge clk) begin
      if (out_valid && cap_n < CAP) begin
         cap_d[cap_n] = out_data;
         cap_l[cap_n] = out_last;
         cap_n = cap_n + 1;
      end
   end

   // k(8) t(4) seed(8) gaps(1)
   localparam logic [20:0] VEC [7] = '{
      {8'd16,  4'd0,  8'h11, 1'b0},
      {8'd16,  4'd1,  8'h22, 1'b0},
      {8'd40,  4'd3,  8'h33, 1'b1},
      {8'd255, 4'd10, 8'h44, 1'b0},
      {8'd100, 4'd8,  8'h55, 1'b1},
      {8'd32,  4'd5,  8'h66, 1'b0},
      {8'd17,  4'd10, 8'h77, 1'b1}
   };

   function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r;
      logic [7:0] x;
      r = 8'h00;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
      end
      return r;
   endfunction

   function automatic logic [7:0] mb(input logic [7:0] s, input int j);
      return s ^ 8'(j * 29 + 3);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // send one codeword; optional mid-message config change (R6)
   task automatic send_cw(input int k, input int t, input logic [7:0] seed,
                          input bit gaps, input bit chg);
      for (int j = 0; j < k; j++) begin
         @(negedge clk);
         if (gaps && (j % 3 == 2)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         if (chg && j == 3) begin
            cfg_k = 8'd30;
            cfg_t = 4'd4;
         end
         in_valid = 1'b1;
         in_data  = mb(seed, j);
         if (j == 0 || j == k - 1) chk(in_ready == 1'b1, "R4 ready in message", int'(in_ready), 1);
      end
      for (int p = 0; p < 2 * t; p++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = 8'hA5;
         if (p == 0 || p == 2 * t - 1) chk(in_ready == 1'b0, "R4 gap slot closed", int'(in_ready), 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b1, "R4 reopens after gap", int'(in_ready), 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_cw(input int k, input int t, input logic [7:0] seed);
      int         n;
      bit         mok;
      bit         lok;
      logic [7:0] root;
      logic [7:0] s;
      n = k + 2 * t;
      chk(cap_n == n, (t == 0) ? "R5 length" : "R2 length", cap_n, n);
      if (cap_n == n) begin
         mok = 1'b1;
         lok = 1'b1;
         for (int j = 0; j < k; j++) if (cap_d[j] != mb(seed, j)) mok = 1'b0;
         for (int j = 0; j < n; j++) if (cap_l[j] != (j == n - 1)) lok = 1'b0;
         chk(mok, "R1 message bytes", int'(mok), 1);
         chk(lok, (t == 0) ? "R5 last marker" : "R2 last marker", int'(lok), 1);
         root = 8'h01;
         for (int i = 0; i < 2 * t; i++) begin
            s = 8'h00;
            for (int j = 0; j < n; j++) s = gm(s, root) ^ cap_d[j];
            if (i == 0 || i == 2 * t - 1) chk(s == 8'h00, "R3 syndrome", s, 0);
            else if (s != 8'h00) chk(1'b0, "R3 syndrome", s, 0);
            root = gm(root, 8'h02);
         end
      end
      cap_n = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
      chk(out_last == 1'b0, "R8 out_last in reset", int'(out_last), 0);
      chk(in_ready == 1'b0, "R8 ready in reset", int'(in_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 ready follows en low", int'(in_ready), 0);
      en = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 ready follows en high", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R8 no output after reset", int'(out_valid), 0);
      cap_n = 0;

      // vector table: R1 R2 R3 R5, gaps exercise R9
      for (int v = 0; v < 7; v++) begin
         cfg_k = VEC[v][20:13];
         cfg_t = VEC[v][12:9];
         send_cw(int'(VEC[v][20:13]), int'(VEC[v][12:9]), VEC[v][8:1], VEC[v][0], 1'b0);
         check_cw(int'(VEC[v][20:13]), int'(VEC[v][12:9]), VEC[v][8:1]);
      end

      // R6: change config mid-codeword, then the next codeword uses it
      cfg_k = 8'd16;
      cfg_t = 4'd2;
      send_cw(16, 2, 8'h5A, 1'b0, 1'b1);
      check_cw(16, 2, 8'h5A);
      send_cw(30, 4, 8'hC3, 1'b0, 1'b0);
      check_cw(30, 4, 8'hC3);

      // R7: drop en inside the check-byte interval
      cfg_k = 8'd16;
      cfg_t = 4'd3;
      for (int j = 0; j < 16; j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = mb(8'h99, j);
      end
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 output quiet", int'(out_valid), 0);
      chk(in_ready == 1'b0, "R7 ready low", int'(in_ready), 0);
      @(negedge clk);
      en = 1'b1;
      cap_n = 0;
      send_cw(16, 3, 8'h3C, 1'b1, 1'b0);
      check_cw(16, 3, 8'h3C);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule